// File: doc/BRIEF.md
# Accumulator ALU with Extended Register

This block is the arithmetic heart of a small accumulator datapath. Each clock edge it takes a 4-bit operation code and a 16-bit operand from the data bus. It computes a new value for the accumulator from that operand and the accumulator's current value, and it stores the result. A second 16-bit register, the extension register, sits below the accumulator. It forms the low half of a 32-bit pair for the double-width shifts and the double-width rotate.

Four condition flags are kept next to the registers: zero, negative, carry and signed overflow. Each operation updates only its own subset of the flags and leaves the rest as they were. This lets sequencing logic elsewhere test a flag several cycles after the operation that set it. The extension register can also be written from the bus by a separate write strobe. Bus source selection and sequencing are outside this block.

Top module: `acc_alu_core`

## Requirements
- R1: While rst_n is low, the accumulator, the extension register and all four flags are cleared to zero.
- R2: Operation code 0 keeps the accumulator. Code 1 loads it with the bus value. Code 2 loads the bitwise complement of the bus. None of the three changes any flag.
- R3: Code 3 clears the accumulator, sets the zero flag and clears the negative flag. Carry and overflow are unchanged.
- R4: Code 4 adds the bus to the accumulator modulo 2^16. Zero and negative follow the result. Carry is the unsigned carry out of bit 15. Overflow is set when the two operands have the same sign and the result has the other sign.
- R5: Code 5 adds like code 4 and updates zero, negative and carry, but leaves overflow unchanged.
- R6: Code 8 adds the bus to the accumulator modulo 2^16 and leaves all four flags unchanged.
- R7: Code 6 stores the bitwise AND of the accumulator and the bus. Code 7 stores the bitwise OR. Both update zero and negative only.
- R8: Code 9 shifts the accumulator left by one and fills bit 0 with zero. Code 11 shifts it right by one and keeps bit 15. Code 13 shifts it right by one and fills bit 15 with zero. In each case carry takes the bit shifted out, zero and negative follow the 16-bit result, and overflow is unchanged.
- R9: Code 14 rotates the accumulator left by one, with old bit 15 moving to bit 0. Carry takes old bit 15, zero and negative follow the result, and overflow is unchanged.
- R10: Codes 10, 12 and 15 act on the 32-bit pair, with the accumulator as the high half. Code 10 shifts the pair left and fills with zero. Code 12 shifts it right and keeps the sign bit. Code 15 rotates it left, with old accumulator bit 15 moving to extension bit 0. Both halves are written back. Carry is the bit leaving the pair: accumulator bit 15 for codes 10 and 15, and extension bit 0 for code 12. Zero is set only when all 32 result bits are zero. Negative is result bit 31. Overflow is unchanged.
- R11: When ext_wr_i is high and the code is not 10, 12 or 15, the extension register loads the bus value. The pair codes take precedence over the strobe. With the strobe low, codes other than 10, 12 and 15 leave the extension register unchanged.
- R12: All outputs are registered. The effect of an operation appears after the rising clock edge that samples it, and never before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| bus_i | input | 16 | Bus operand |
| ext_wr_i | input | 1 | Extension register write strobe |
| acc_o | output | 16 | Accumulator value |
| ext_o | output | 16 | Extension register value |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
Every result is due exactly one rising edge after the code and operand are presented: accumulator, extension register and flags alike. There is no multi-cycle operation. The bench drives inputs on the falling edge and compares all six outputs with its arithmetic model on the next falling edge. Shortly after each drive, it also confirms that nothing has moved yet, which checks that no output is combinational. The sweep covers all sixteen codes, with corner accumulator, extension and bus values and both strobe levels. A long pseudo-random stream follows, so that each code meets flag states left behind by every other code.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_KEEP    = 4'd0,
    OP_LOAD    = 4'd1,
    OP_LOADN   = 4'd2,
    OP_CLEAR   = 4'd3,
    OP_ADD_V   = 4'd4,
    OP_ADD_C   = 4'd5,
    OP_AND     = 4'd6,
    OP_OR      = 4'd7,
    OP_ADD_Q   = 4'd8,
    OP_SHL     = 4'd9,
    OP_PAIR_SL = 4'd10,
    OP_ASR     = 4'd11,
    OP_PAIR_SR = 4'd12,
    OP_SHR     = 4'd13,
    OP_ROL     = 4'd14,
    OP_PAIR_RL = 4'd15
  } alu_op_e;

  // Which flags an operation writes and whether it acts on the 32-bit pair.
  typedef struct packed {
    logic wr_zn;
    logic wr_c;
    logic wr_o;
    logic pair;
  } flag_ctl_t;

  function automatic flag_ctl_t decode_flags(alu_op_e op);
    flag_ctl_t f;
    f = '0;
    case (op)
      OP_CLEAR:                      f.wr_zn = 1'b1;
      OP_ADD_V:  begin f.wr_zn = 1'b1; f.wr_c = 1'b1; f.wr_o = 1'b1; end
      OP_ADD_C:  begin f.wr_zn = 1'b1; f.wr_c = 1'b1; end
      OP_AND, OP_OR:                 f.wr_zn = 1'b1;
      OP_SHL, OP_ASR, OP_SHR, OP_ROL: begin f.wr_zn = 1'b1; f.wr_c = 1'b1; end
      OP_PAIR_SL, OP_PAIR_SR, OP_PAIR_RL: begin
        f.wr_zn = 1'b1; f.wr_c = 1'b1; f.pair = 1'b1;
      end
      default: f = '0;
    endcase
    return f;
  endfunction

  function automatic logic is_add(alu_op_e op);
    return (op == OP_ADD_V) || (op == OP_ADD_C) || (op == OP_ADD_Q);
  endfunction

endpackage

// File: rtl/acc_alu_adder.sv
`timescale 1ns/1ps
module acc_alu_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         ovf_o
);

  // Returns {overflow, carry, sum}.
  function automatic logic [W+1:0] add_full(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    logic       v;
    s = {1'b0, a} + {1'b0, b};
    v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    return {v, s};
  endfunction

  logic [W+1:0] full;
  assign full    = add_full(a_i, b_i);
  assign sum_o   = full[W-1:0];
  assign carry_o = full[W];
  assign ovf_o   = full[W+1];

endmodule

// File: rtl/acc_alu_shifter.sv
`timescale 1ns/1ps
module acc_alu_shifter
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         out_bit_o
);

  localparam int RW = 2*W + 1;

  // Returns {bit leaving the operand, new high half, new low half}.
  function automatic logic [RW-1:0] shift_one(alu_op_e op, logic [W-1:0] a, logic [W-1:0] h);
    logic [W-1:0] nh, nl;
    logic         c;
    nh = a; nl = h; c = 1'b0;
    case (op)
      OP_SHL:     begin c = a[W-1]; nh = {a[W-2:0], 1'b0}; end
      OP_ASR:     begin c = a[0];   nh = {a[W-1], a[W-1:1]}; end
      OP_SHR:     begin c = a[0];   nh = {1'b0, a[W-1:1]}; end
      OP_ROL:     begin c = a[W-1]; nh = {a[W-2:0], a[W-1]}; end
      OP_PAIR_SL: begin c = a[W-1]; nh = {a[W-2:0], h[W-1]}; nl = {h[W-2:0], 1'b0}; end
      OP_PAIR_SR: begin c = h[0];   nh = {a[W-1], a[W-1:1]}; nl = {a[0], h[W-1:1]}; end
      OP_PAIR_RL: begin c = a[W-1]; nh = {a[W-2:0], h[W-1]}; nl = {h[W-2:0], a[W-1]}; end
      default:    begin nh = a; nl = h; c = 1'b0; end
    endcase
    return {c, nh, nl};
  endfunction

  logic [RW-1:0] r;
  assign r         = shift_one(op_i, hi_i, lo_i);
  assign out_bit_o = r[RW-1];
  assign hi_o      = r[2*W-1:W];
  assign lo_o      = r[W-1:0];

endmodule

// File: rtl/acc_alu_flags.sv
`timescale 1ns/1ps
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  flag_ctl_t    ctl_i,
  input  logic [W-1:0] res_hi_i,
  input  logic [W-1:0] res_lo_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);

  logic hi_zero, lo_zero, res_zero;
  assign hi_zero  = (res_hi_i == '0);
  assign lo_zero  = (res_lo_i == '0);
  assign res_zero = ctl_i.pair ? (hi_zero && lo_zero) : hi_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zero_o  <= 1'b0;
      neg_o   <= 1'b0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      if (ctl_i.wr_zn) begin
        zero_o <= res_zero;
        neg_o  <= res_hi_i[W-1];
      end
      if (ctl_i.wr_c) carry_o <= carry_i;
      if (ctl_i.wr_o) ovf_o   <= ovf_i;
    end
  end

  // Only adds with overflow enabled may touch the overflow flag (R5, R8).
  assert_o_only_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i.wr_o |=> $stable(ovf_o));

  // A pair result with a nonzero low half can never report zero (R10).
  assert_pair_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.pair && !lo_zero) |=> !zero_o);

endmodule

// File: rtl/acc_alu_core.sv
`timescale 1ns/1ps
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] bus_i,
  input  logic         ext_wr_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] ext_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         carry_o,
  output logic         ovf_o
);

  alu_op_e   op;
  flag_ctl_t fctl;
  logic      add_op, pair_op, quiet_op;

  assign op       = alu_op_e'(op_i);
  assign fctl     = decode_flags(op);
  assign add_op   = is_add(op);
  assign pair_op  = fctl.pair;
  assign quiet_op = (op == OP_KEEP) || (op == OP_LOAD) || (op == OP_LOADN) || (op == OP_ADD_Q);

  logic [W-1:0] acc_q, ext_q;
  logic [W-1:0] add_sum, sh_hi, sh_lo;
  logic         add_c, add_v, sh_c;

  acc_alu_adder #(.W(W)) u_add (
    .a_i(acc_q), .b_i(bus_i), .sum_o(add_sum), .carry_o(add_c), .ovf_o(add_v)
  );

  acc_alu_shifter #(.W(W)) u_shift (
    .op_i(op), .hi_i(acc_q), .lo_i(ext_q), .hi_o(sh_hi), .lo_o(sh_lo), .out_bit_o(sh_c)
  );

  logic [W-1:0] acc_nx, ext_nx;
  logic         carry_src;

  always_comb begin
    case (op)
      OP_KEEP:  acc_nx = acc_q;
      OP_LOAD:  acc_nx = bus_i;
      OP_LOADN: acc_nx = ~bus_i;
      OP_CLEAR: acc_nx = '0;
      OP_ADD_V, OP_ADD_C, OP_ADD_Q: acc_nx = add_sum;
      OP_AND:   acc_nx = acc_q & bus_i;
      OP_OR:    acc_nx = acc_q | bus_i;
      default:  acc_nx = sh_hi;
    endcase
  end

  assign ext_nx    = pair_op ? sh_lo : (ext_wr_i ? bus_i : ext_q);
  assign carry_src = add_op ? add_c : sh_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= '0;
    end else begin
      acc_q <= acc_nx;
      ext_q <= ext_nx;
    end
  end

  acc_alu_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .ctl_i(fctl),
    .res_hi_i(acc_nx), .res_lo_i(ext_nx),
    .carry_i(carry_src), .ovf_i(add_v),
    .zero_o(zero_o), .neg_o(neg_o), .carry_o(carry_o), .ovf_o(ovf_o)
  );

  assign acc_o = acc_q;
  assign ext_o = ext_q;

  // Keep, load, complement-load and quiet add leave every flag alone (R2, R6).
  assert_quiet_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_op |=> $stable({zero_o, neg_o, carry_o, ovf_o}));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd3) |=> (acc_o == '0 && zero_o && !neg_o && $stable({carry_o, ovf_o})));

  assert_add_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd4) |=> (acc_o == W'($past(acc_o) + $past(bus_i))));

  assert_quiet_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd8) |=> (acc_o == W'($past(acc_o) + $past(bus_i))));

  assert_logic_co_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd6 || op_i == 4'd7) |=> $stable({carry_o, ovf_o}));

  assert_shl_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd9) |=> (carry_o == $past(acc_o[W-1]) && acc_o[0] == 1'b0));

  assert_rol_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd14) |=> (acc_o[0] == $past(acc_o[W-1]) && carry_o == $past(acc_o[W-1])));

  assert_pair_shl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd10) |=> ({acc_o, ext_o} == {$past(acc_o[W-2:0]), $past(ext_o), 1'b0}));

  assert_ext_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr_i && !pair_op) |=> (ext_o == $past(bus_i)));

  assert_ext_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_wr_i && !pair_op) |=> $stable(ext_o));

endmodule

// File: tb/sim_acc_alu_core.sv
`timescale 1ns/1ps
module sim_acc_alu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [15:0] bus_i = 16'd0;
  logic        ext_wr_i = 1'b0;
  logic [15:0] acc_o, ext_o;
  logic        zero_o, neg_o, carry_o, ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .bus_i(bus_i), .ext_wr_i(ext_wr_i),
    .acc_o(acc_o), .ext_o(ext_o), .zero_o(zero_o), .neg_o(neg_o),
    .carry_o(carry_o), .ovf_o(ovf_o)
  );

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  // Bench model of the architectural state.
  longint m_acc = 0, m_ext = 0;
  bit     m_z = 0, m_n = 0, m_c = 0, m_o = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2:     return "R2";
      3:           return "R3";
      4:           return "R4";
      5:           return "R5";
      8:           return "R6";
      6, 7:        return "R7";
      9, 11, 13:   return "R8";
      14:          return "R9";
      default:     return "R10";
    endcase
  endfunction

  function automatic longint sgn(input longint v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  // Apply one operation at a falling edge, check the result one edge later.
  task automatic step(input int op, input longint b, input bit ew);
    longint a, h, na, nh, s, t, p, p2;
    bit     nz, nn, nc, no;
    string  rq;
    op_i = op[3:0]; bus_i = b[15:0]; ext_wr_i = ew;
    #1;
    // R12: nothing moves before the sampling edge.
    chk("R12", "acc before edge", acc_o, m_acc);
    chk("R12", "ext before edge", ext_o, m_ext);
    a = m_acc; h = m_ext; na = a; nh = h;
    nz = m_z; nn = m_n; nc = m_c; no = m_o;
    case (op)
      0: na = a;
      1: na = b;
      2: na = 65535 - b;
      3: begin na = 0; nz = 1; nn = 0; end
      4, 5, 8: begin
        s = a + b; na = s % 65536;
        if (op != 8) begin
          nz = (na == 0); nn = (na >= 32768); nc = (s >= 65536);
          if (op == 4) begin
            t = sgn(a) + sgn(b);
            no = (t > 32767) || (t < -32768);
          end
        end
      end
      6: begin na = a & b; nz = (na == 0); nn = (na >= 32768); end
      7: begin na = a | b; nz = (na == 0); nn = (na >= 32768); end
      9:  begin nc = (a >= 32768); na = (a * 2) % 65536; end
      11: begin nc = a[0]; na = a / 2 + ((a >= 32768) ? 32768 : 0); end
      13: begin nc = a[0]; na = a / 2; end
      14: begin nc = (a >= 32768); na = (a * 2) % 65536 + a / 32768; end
      default: begin
        p = a * 65536 + h;
        if (op == 10) begin nc = (a >= 32768); p2 = (p * 2) % 64'h1_0000_0000; end
        else if (op == 12) begin nc = h[0]; p2 = p / 2 + ((a >= 32768) ? 64'h8000_0000 : 0); end
        else begin nc = (a >= 32768); p2 = (p * 2) % 64'h1_0000_0000 + a / 32768; end
        na = p2 / 65536; nh = p2 % 65536;
        nz = (p2 == 0); nn = (na >= 32768);
      end
    endcase
    if (op inside {9, 11, 13, 14}) begin nz = (na == 0); nn = (na >= 32768); end
    if (!(op inside {10, 12, 15}) && ew) nh = b;
    @(posedge clk);
    @(negedge clk);
    rq = req_of(op);
    chk(rq, "acc", acc_o, na);
    chk((ew && !(op inside {10, 12, 15})) ? "R11" : rq, "ext", ext_o, nh);
    chk(rq, "zero", zero_o, nz);
    chk(rq, "neg", neg_o, nn);
    chk(rq, "carry", carry_o, nc);
    chk(rq, "ovf", ovf_o, no);
    m_acc = na; m_ext = nh; m_z = nz; m_n = nn; m_c = nc; m_o = no;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    longint pat[8];
    longint rs;
    pat[0] = 0;      pat[1] = 1;      pat[2] = 16'h7FFF; pat[3] = 16'h8000;
    pat[4] = 16'hFFFF; pat[5] = 16'h5555; pat[6] = 16'hAAAA; pat[7] = 16'h8001;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "acc reset", acc_o, 0);
    chk("R1", "ext reset", ext_o, 0);
    chk("R1", "flags reset", {zero_o, neg_o, carry_o, ovf_o}, 0);
    rst_n = 1'b1;

    // Directed sweep: every code against corner register and bus values.
    for (int op = 0; op < 16; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          step(0, pat[(ia + ib) % 8], 1'b1);        // R11: extension from bus
          step(1, pat[ia], 1'b0);                   // R2: load accumulator
          step(op, pat[ib], (ib % 3) == 0);
        end
      end
    end

    // Pseudo-random stream mixing codes, operands and strobe.
    rs = 64'h1234_5678;
    for (int k = 0; k < 4000; k++) begin
      rs = (rs * 1103515245 + 12345) % 64'h8000_0000;
      step(int'((rs / 65536) % 16), rs % 65536, ((rs / 1048576) % 4) == 0);
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule